// File: doc/BRIEF.md
# Received-Cell Counters with Rollover Service Request

This block keeps track of how many cells have arrived. A single global counter counts every arrival strobe, whether or not the cell will later be discarded. A bank of per-channel counters counts only the cells tagged with a valid channel index. All counters are free-running and wrap to zero.

Each wrap sets a sticky status flag. That flag stays set until software clears it with its own clear strobe. A service-request line asks the CPU for attention whenever an enabled flag is set. The global flag has its own enable. All per-channel flags share one enable.

A port field names the channel whose counter wrapped most recently. The CPU reads that field to find out which channel needs servicing. It reads the global count directly and reads any one channel's count through a select input.

Top module: `cell_count_svc`

## Requirements
- R1: The global count increases by exactly one on each cycle with `cell_vld` high, for any `cell_ch` value including indices at or above `N_CH`. It wraps from all-ones to zero and holds when `cell_vld` is low.
- R2: `glob_roll` becomes 1 on the cycle after the global count wraps. It stays 1 until a cycle with `glob_clr` high, and is 0 on the cycle after that clear.
- R3: Channel i's count increases by one only on strobes with `cell_ch == i` and wraps like the global one. Strobes with `cell_ch >= N_CH` change no channel count.
- R4: Bit i of `ch_roll` is set on the cycle after channel i wraps. It is cleared only by bit i of `ch_clr`, and other channels' flags are unaffected.
- R5: `svc_req` is high exactly when (`glob_se` and `glob_roll`) or (`ch_se` and any bit of `ch_roll`). It falls once all enabled flags are cleared.
- R6: On each channel wrap, `svc_port` takes that channel's index on the next cycle, whatever the enables are. It otherwise holds, so it always names the latest wrap while earlier flags stay set.
- R7: When a wrap and a clear of the same flag fall in the same cycle, the flag is 1 afterwards.
- R8: A synchronous active-low reset sets all counts, flags and `svc_port` to zero, so `svc_req` is 0.
- R9: `ch_count` shows the count of channel `rd_ch`, and shows zero when `rd_ch >= N_CH`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cell_vld | input | 1 | One received cell this cycle |
| cell_ch | input | CH_W | Channel index of the received cell |
| glob_clr | input | 1 | Software clear of the global wrap flag |
| ch_clr | input | N_CH | Software clear, one bit per channel wrap flag |
| glob_se | input | 1 | Service enable for the global wrap flag |
| ch_se | input | 1 | Service enable shared by all channel wrap flags |
| rd_ch | input | CH_W | Channel whose count is shown on `ch_count` |
| glob_count | output | CNT_W | Global received-cell count |
| ch_count | output | CNT_W | Count of the selected channel |
| glob_roll | output | 1 | Sticky global wrap flag |
| ch_roll | output | N_CH | Sticky per-channel wrap flags |
| svc_req | output | 1 | Service request to the CPU |
| svc_port | output | CH_W | Channel of the most recent per-channel wrap |

## Verification
Bursts go to single channels, to an out-of-range index and to one channel long enough to wrap. Comparing the global count with the selected channel's count separates global-only counting from per-channel counting. Wrapping two different channels before any clear shows that `svc_port` follows the latest wrap while both flags remain. Enables are toggled one at a time against set flags to separate the global gating from the channel gating. A wrap strobe coinciding with that channel's clear shows which of the two has priority.

// File: rtl/cellcnt_pkg.sv
// Package: shared helpers for the received-cell counter block.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package cellcnt_pkg;

    // Width of an index able to address n channels (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cellcnt_roll_counter.sv
// Module: one free-running wrap counter with a sticky wrap flag.
// What it does: counts inc pulses, wraps at all-ones, and sets flag on a wrap.
// Assumes: clr is a one-cycle software strobe; a wrap in the same cycle as
// clr leaves the flag set.
module cellcnt_roll_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count,
    output logic         flag,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // Wrap pulse: this increment takes the count from all-ones to zero.
    always_comb wrap = inc && (count == TOP);

    // Counter register: advance on every inc.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + 1'b1;
    end

    // Sticky flag: a wrap sets it, clr alone clears it, the wrap wins.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (wrap) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

    p_incr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> count == W'($past(count) + 1'b1));
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    p_roll_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && count == TOP) |=> flag);
endmodule

// File: rtl/cellcnt_svc_track.sv
// Module: service-request combiner and service-port register.
// What it does: ORs the enabled wrap flags into one request line and
// records the index of the channel that wrapped most recently.
// Assumes: at most one channel wraps per cycle (one arrival strobe).
module cellcnt_svc_track #(
    parameter int N_CH = 6,
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] ch_wrap,
    input  logic [N_CH-1:0] ch_flag,
    input  logic            glob_flag,
    input  logic            glob_se,
    input  logic            ch_se,
    output logic            svc_req,
    output logic [CH_W-1:0] svc_port
);
    logic [CH_W-1:0] wrap_idx;
    logic            any_wrap;

    // Encoder: index of the wrapping channel.
    always_comb begin
        wrap_idx = '0;
        any_wrap = 1'b0;
        for (int i = 0; i < N_CH; i++) begin
            if (ch_wrap[i]) begin
                wrap_idx = CH_W'(i);
                any_wrap = 1'b1;
            end
        end
    end

    // Request line: each flag source gated by its own enable.
    always_comb svc_req = (glob_se && glob_flag) || (ch_se && (|ch_flag));

    // Port register: capture the latest wrapping channel.
    always_ff @(posedge clk) begin
        if (!rst_n)        svc_port <= '0;
        else if (any_wrap) svc_port <= wrap_idx;
    end

    p_one_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_wrap));
    p_port_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(|ch_wrap) |=> $stable(svc_port));
endmodule

// File: rtl/cell_count_svc.sv
// Module: top of the received-cell counters with rollover service.
// What it does: one global counter over all arrivals, one counter per
// channel, sticky wrap flags, a gated service request and a port field.
// Assumes: one arrival per cycle at most; indices >= N_CH count globally only.
module cell_count_svc
    import cellcnt_pkg::*;
#(
    parameter int N_CH  = 6,
    parameter int CNT_W = 16,
    parameter int CH_W  = idx_width(N_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_vld,
    input  logic [CH_W-1:0]  cell_ch,
    input  logic             glob_clr,
    input  logic [N_CH-1:0]  ch_clr,
    input  logic             glob_se,
    input  logic             ch_se,
    input  logic [CH_W-1:0]  rd_ch,
    output logic [CNT_W-1:0] glob_count,
    output logic [CNT_W-1:0] ch_count,
    output logic             glob_roll,
    output logic [N_CH-1:0]  ch_roll,
    output logic             svc_req,
    output logic [CH_W-1:0]  svc_port
);
    logic [CNT_W-1:0] ch_cnt [N_CH];
    logic [N_CH-1:0]  ch_inc;
    logic [N_CH-1:0]  ch_wrap;
    logic             glob_wrap;

    // Global counter: every arrival strobe counts.
    cellcnt_roll_counter #(.W(CNT_W)) u_glob (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cell_vld),
        .clr   (glob_clr),
        .count (glob_count),
        .flag  (glob_roll),
        .wrap  (glob_wrap)
    );

    // Per-channel counters: one per channel index.
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        assign ch_inc[g] = cell_vld && (cell_ch == CH_W'(g));
        cellcnt_roll_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (ch_inc[g]),
            .clr   (ch_clr[g]),
            .count (ch_cnt[g]),
            .flag  (ch_roll[g]),
            .wrap  (ch_wrap[g])
        );
    end

    // Read mux: selected channel's count, zero for out-of-range selects.
    always_comb begin
        ch_count = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (rd_ch == CH_W'(i)) ch_count = ch_cnt[i];
        end
    end

    // Service request and port field.
    cellcnt_svc_track #(.N_CH(N_CH), .CH_W(CH_W)) u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_wrap   (ch_wrap),
        .ch_flag   (ch_roll),
        .glob_flag (glob_roll),
        .glob_se   (glob_se),
        .ch_se     (ch_se),
        .svc_req   (svc_req),
        .svc_port  (svc_port)
    );

    p_oor_no_ch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_vld && (int'(cell_ch) >= N_CH)) |-> (ch_inc == '0));
    p_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_se && !ch_se) |-> !svc_req);
    p_glob_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        glob_wrap |=> (glob_roll && glob_count == '0));
endmodule

// File: tb/tb_cell_count_svc.sv
module tb_cell_count_svc;
    localparam int NCH = 6;
    localparam int CW  = 8;
    localparam int IW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cell_vld = 1'b0;
    logic [IW-1:0] cell_ch = '0;
    logic          glob_clr = 1'b0;
    logic [NCH-1:0] ch_clr = '0;
    logic          glob_se = 1'b0;
    logic          ch_se = 1'b0;
    logic [IW-1:0] rd_ch = '0;
    logic [CW-1:0] glob_count, ch_count;
    logic          glob_roll, svc_req;
    logic [NCH-1:0] ch_roll;
    logic [IW-1:0] svc_port;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cell_count_svc #(.N_CH(NCH), .CNT_W(CW), .CH_W(IW)) dut (
        .clk(clk), .rst_n(rst_n), .cell_vld(cell_vld), .cell_ch(cell_ch),
        .glob_clr(glob_clr), .ch_clr(ch_clr), .glob_se(glob_se),
        .ch_se(ch_se), .rd_ch(rd_ch), .glob_count(glob_count),
        .ch_count(ch_count), .glob_roll(glob_roll), .ch_roll(ch_roll),
        .svc_req(svc_req), .svc_port(svc_port)
    );

    typedef struct packed {
        logic [2:0] ch;
        logic [9:0] n;
        logic [2:0] rd;
        logic [7:0] exp_rd;
        logic [7:0] exp_glob;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{3'd0, 10'd5,   3'd0, 8'd5,   8'd5},
        '{3'd3, 10'd10,  3'd3, 8'd10,  8'd15},
        '{3'd6, 10'd7,   3'd0, 8'd5,   8'd22},
        '{3'd5, 10'd3,   3'd5, 8'd3,   8'd25},
        '{3'd0, 10'd250, 3'd0, 8'd255, 8'd19},
        '{3'd0, 10'd1,   3'd0, 8'd0,   8'd20}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int ch, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cell_vld = 1'b1;
            cell_ch  = IW'(ch);
        end
        @(negedge clk);
        cell_vld = 1'b0;
    endtask

    task automatic clr_ch(input logic [NCH-1:0] m);
        @(negedge clk);
        ch_clr = m;
        @(negedge clk);
        ch_clr = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        chk("R8 glob_count", glob_count, 0);
        chk("R8 ch_count", ch_count, 0);
        chk("R8 flags", {glob_roll, ch_roll}, 0);
        chk("R8 svc_port", svc_port, 0);
        chk("R8 svc_req", svc_req, 0);

        // R1 R3 R9: table walk
        for (int v = 0; v < 6; v++) begin
            send(VEC[v].ch, VEC[v].n);
            rd_ch = VEC[v].rd;
            #1;
            chk("R1 glob_count", glob_count, VEC[v].exp_glob);
            chk("R3 R9 ch_count", ch_count, VEC[v].exp_rd);
        end
        rd_ch = 3'd7; #1;
        chk("R9 out-of-range read", ch_count, 0);
        rd_ch = 3'd6; #1;
        chk("R3 index 6 not counted", ch_count, 0);

        // R2 R4: flags from global wrap (row 4) and ch0 wrap (row 5)
        chk("R2 glob_roll set", glob_roll, 1);
        chk("R4 ch_roll", ch_roll, 6'b000001);
        chk("R6 svc_port ch0", svc_port, 0);
        chk("R5 no enables", svc_req, 0);
        glob_se = 1'b1; #1;
        chk("R5 glob_se only", svc_req, 1);
        glob_se = 1'b0; ch_se = 1'b1; #1;
        chk("R5 ch_se only", svc_req, 1);

        // R6: second channel wraps, both flags kept
        send(3, 246);
        rd_ch = 3'd3; #1;
        chk("R3 ch3 wrapped", ch_count, 0);
        chk("R1 glob after ch3", glob_count, 10);
        chk("R6 both flags", ch_roll, 6'b001001);
        chk("R6 svc_port ch3", svc_port, 3);

        // R4: clear ch0 only
        clr_ch(6'b000001);
        chk("R4 ch0 cleared only", ch_roll, 6'b001000);
        chk("R4 glob unaffected", glob_roll, 1);

        // R2: clear global flag
        @(negedge clk); glob_clr = 1'b1;
        @(negedge clk); glob_clr = 1'b0;
        chk("R2 glob cleared", glob_roll, 0);
        chk("R5 req via ch3", svc_req, 1);

        // R7: wrap and clear in the same cycle
        send(5, 252);
        @(negedge clk);
        cell_vld = 1'b1; cell_ch = 3'd5; ch_clr = 6'b100000;
        @(negedge clk);
        cell_vld = 1'b0; ch_clr = '0;
        chk("R7 wrap beats clear", ch_roll[5], 1);
        chk("R6 svc_port ch5", svc_port, 5);
        chk("R1 glob after ch5", glob_count, 7);

        // R5: clear all channel flags, request falls, port holds
        clr_ch('1);
        chk("R5 req falls", svc_req, 0);
        chk("R6 port holds", svc_port, 5);

        // R8: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        send(1, 3);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        rd_ch = 3'd1; #1;
        chk("R8 glob after reset", glob_count, 0);
        chk("R8 ch1 after reset", ch_count, 0);
        chk("R8 port after reset", svc_port, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule